// File: doc/BRIEF.md
# Vector Float-to-Integer Lane Converter

This block turns a wide register of binary32 floating-point lanes into signed integer lanes in one pass. Each lane works on its own: a floating-point word is classified, shifted to integer scale, rounded under one of six rounding rules, and then either clamped to the destination range or wrapped to its low bits. The destination is a signed 32-bit integer per lane, or a signed 16-bit integer when the narrow form is chosen. In the narrow form the 16-bit result sits sign-extended in its 32-bit lane slot.

A per-lane execution mask picks which lanes produce a result. A lane whose mask bit is clear writes zero. The conversion runs in a three-stage pipeline: decode, round, then limit and merge. A new operand set can enter on every clock, and the output strobe follows the input strobe three cycles later.

Inside each lane, the decode stage sorts the operand into one of seven classes: zero, subnormal, fractional (needs rounding), whole (exact and below 2^32), huge (exact and at or above 2^32), infinity and NaN. The class travels down the pipe with the operand. In the last stage a case on the class selects between the clamp value, the wrapped value and zero.

Top module: `f2i_vec_conv`

## Requirements
- R1: `rnd_mode` selects the rounding rule. Code 0 is nearest with ties to even, 1 is away from zero, 2 is toward minus infinity, 3 is toward plus infinity, 4 is toward zero. Code 5 is round-to-odd: truncate toward zero, then set the magnitude LSB to 1 if any discarded bit was nonzero.
- R2: Codes 6 and 7 give exactly the same results as code 0.
- R3: With `sat_en`=1, a rounded result above the destination maximum gives the maximum and one below the minimum gives the minimum. The limits are 0x7FFFFFFF / 0x80000000 for the 32-bit form and 32767 / -32768 for the 16-bit form. Plus and minus infinity give the maximum and the minimum.
- R4: With `sat_en`=0, an out-of-range result gives the low 32 bits of the two's-complement rounded value. In the 16-bit form it gives the low 16 bits sign-extended. Infinities give 0.
- R5: A lane whose `lane_mask` bit is 0 outputs 0, whatever its operand, mode or saturation setting.
- R6: A NaN operand (exponent all ones, nonzero fraction) outputs 0 with saturation on or off.
- R7: Zero, minus zero, subnormals and magnitudes below one are rounded like any other value. For example, a positive subnormal gives 1 under code 3, a negative subnormal gives -1 under code 2, and both give 0 under code 4.
- R8: `out_valid` equals `in_valid` delayed by exactly 3 clocks, and a new operand set is accepted on every clock. Lane i reads `src_vec[32i+31:32i]` (sign bit 31, exponent 30:23, fraction 22:0) and writes `dst_vec[32i+31:32i]`.
- R9: With `narrow16`=1, the 16-bit limits apply and every lane's bits 31:16 equal its bit 15.
- R10: While `rst_n` is low, `out_valid` is 0 and `dst_vec` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set present this cycle |
| src_vec | input | 2048 | 64 binary32 source lanes |
| lane_mask | input | 64 | Execution mask, one bit per lane |
| rnd_mode | input | 3 | Rounding rule code |
| sat_en | input | 1 | 1 = clamp on overflow, 0 = wrap |
| narrow16 | input | 1 | 1 = signed 16-bit destination |
| out_valid | output | 1 | Result present this cycle |
| dst_vec | output | 2048 | 64 integer destination lanes |

## Verification
The rounding increment and the overflow decision can land on the same lane in the same cycle. Examples are 32767.5 rounded to nearest in the 16-bit form, or -32768.5 rounded away from zero: the carry from rounding is what pushes the value past the limit. Masking can also coincide with a saturating or NaN operand, and the zero merge has to win. These cases are provoked by a fixed operand pattern swept over every mode, saturation and width combination, and then under random masks. The results are judged lane by lane against a behavioural model that uses real arithmetic.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

    localparam int FP_W   = 32;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        RND_NEAR_EVEN = 3'd0,
        RND_AWAY      = 3'd1,
        RND_FLOOR     = 3'd2,
        RND_CEIL      = 3'd3,
        RND_ZERO      = 3'd4,
        RND_ODD       = 3'd5
    } rnd_e;

    // Lane operand class carried down the pipeline
    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_TINY,
        CLS_FRAC,
        CLS_WHOLE,
        CLS_HUGE,
        CLS_INF,
        CLS_NAN
    } lane_cls_e;

    typedef struct packed {
        logic           sgn;
        lane_cls_e      cls;
        logic [FP_W-1:0] mag;
        logic           grd;
        logic           stk;
    } dec_t;

    typedef struct packed {
        logic          sgn;
        lane_cls_e     cls;
        logic [FP_W:0] mag;
    } rnd_t;

endpackage

// File: rtl/f2i_lane_decode.sv
module f2i_lane_decode
    import f2i_pkg::*;
(
    input  logic [FP_W-1:0] fp,
    output dec_t            dec
);
    localparam int BIAS_INT = 150;   // exponent at which the LSB weight is 1
    localparam int HUGE_EXP = 159;   // exponent at which magnitude reaches 2^32
    localparam int EXT_W    = 24 + BIAS_INT;

    logic [7:0]       ex;
    logic [22:0]      fr;
    logic [23:0]      sig;
    logic [7:0]       rsh;
    logic [7:0]       lsh;
    logic [EXT_W-1:0] ext;

    always_comb begin
        ex  = fp[30:23];
        fr  = fp[22:0];
        sig = {|ex, fr};
        rsh = 8'(BIAS_INT) - ex;
        lsh = ex - 8'(BIAS_INT);
        ext = {sig, {BIAS_INT{1'b0}}} >> rsh;

        dec     = '0;
        dec.sgn = fp[31];
        if (ex == 8'hFF) begin
            dec.cls = (fr != '0) ? CLS_NAN : CLS_INF;
        end else if (ex == 8'h00 && fr == '0) begin
            dec.cls = CLS_ZERO;
        end else if (ex < 8'(BIAS_INT)) begin
            dec.cls = (ex == 8'h00) ? CLS_TINY : CLS_FRAC;
            dec.mag = {8'b0, ext[EXT_W-1:BIAS_INT]};
            dec.grd = ext[BIAS_INT-1];
            dec.stk = |ext[BIAS_INT-2:0];
        end else if (ex < 8'(HUGE_EXP)) begin
            dec.cls = CLS_WHOLE;
            dec.mag = FP_W'(sig) << lsh;
        end else begin
            dec.cls = CLS_HUGE;
            dec.mag = FP_W'(sig) << lsh;
        end
    end

endmodule

// File: rtl/f2i_lane_round.sv
module f2i_lane_round
    import f2i_pkg::*;
(
    input  dec_t              d,
    input  logic [MODE_W-1:0] mode,
    output rnd_t              r
);
    logic inexact;
    logic inc;
    logic force_odd;

    always_comb begin
        inexact   = d.grd | d.stk;
        force_odd = 1'b0;
        unique case (rnd_e'(mode))
            RND_AWAY:  inc = inexact;
            RND_FLOOR: inc = d.sgn & inexact;
            RND_CEIL:  inc = ~d.sgn & inexact;
            RND_ZERO:  inc = 1'b0;
            RND_ODD: begin
                inc       = 1'b0;
                force_odd = inexact;
            end
            default:   inc = d.grd & (d.stk | d.mag[0]);
        endcase

        r.sgn = d.sgn;
        r.cls = d.cls;
        r.mag = {1'b0, d.mag} + (FP_W+1)'(inc);
        if (force_odd) begin
            r.mag[0] = 1'b1;
        end
    end

endmodule

// File: rtl/f2i_lane_pack.sv
module f2i_lane_pack
    import f2i_pkg::*;
(
    input  rnd_t            r,
    input  logic            sat,
    input  logic            narrow,
    input  logic            mbit,
    output logic [FP_W-1:0] q
);
    logic [FP_W:0]   pos_lim;
    logic [FP_W:0]   neg_lim;
    logic [FP_W-1:0] sat_pos;
    logic [FP_W-1:0] sat_neg;
    logic [FP_W-1:0] wrapped;
    logic [FP_W-1:0] fitted;
    logic            ovf;

    always_comb begin
        pos_lim = narrow ? 33'd32767 : 33'h0_7FFF_FFFF;
        neg_lim = narrow ? 33'd32768 : 33'h0_8000_0000;
        sat_pos = narrow ? 32'h0000_7FFF : 32'h7FFF_FFFF;
        sat_neg = narrow ? 32'hFFFF_8000 : 32'h8000_0000;
        ovf     = (r.cls == CLS_HUGE) || (r.cls == CLS_INF) ||
                  (r.sgn ? (r.mag > neg_lim) : (r.mag > pos_lim));
        wrapped = r.sgn ? (~r.mag[FP_W-1:0] + 32'd1) : r.mag[FP_W-1:0];
        fitted  = narrow ? {{16{wrapped[15]}}, wrapped[15:0]} : wrapped;

        unique case (r.cls)
            CLS_NAN:  q = '0;
            CLS_INF:  q = sat ? (r.sgn ? sat_neg : sat_pos) : '0;
            CLS_ZERO: q = '0;
            CLS_TINY, CLS_FRAC, CLS_WHOLE, CLS_HUGE:
                q = (sat && ovf) ? (r.sgn ? sat_neg : sat_pos) : fitted;
            default:  q = '0;
        endcase

        if (!mbit) begin
            q = '0;
        end
    end

endmodule

// File: rtl/f2i_lane.sv
module f2i_lane
    import f2i_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FP_W-1:0]   fp,
    input  logic [MODE_W-1:0] mode_a,
    input  logic              sat_b,
    input  logic              narrow_b,
    input  logic              mbit_b,
    output logic [FP_W-1:0]   q
);
    dec_t            dec_d, dec_q;
    rnd_t            rnd_d, rnd_q;
    logic [FP_W-1:0] pack_d;

    f2i_lane_decode u_dec (
        .fp  (fp),
        .dec (dec_d)
    );

    f2i_lane_round u_rnd (
        .d    (dec_q),
        .mode (mode_a),
        .r    (rnd_d)
    );

    f2i_lane_pack u_pack (
        .r      (rnd_q),
        .sat    (sat_b),
        .narrow (narrow_b),
        .mbit   (mbit_b),
        .q      (pack_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= '0;
            rnd_q <= '0;
            q     <= '0;
        end else begin
            dec_q <= dec_d;
            rnd_q <= rnd_d;
            q     <= pack_d;
        end
    end

endmodule

// File: rtl/f2i_vec_conv.sv
module f2i_vec_conv
    import f2i_pkg::*;
#(
    parameter int LANES = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [LANES*FP_W-1:0]   src_vec,
    input  logic [LANES-1:0]        lane_mask,
    input  logic [MODE_W-1:0]       rnd_mode,
    input  logic                    sat_en,
    input  logic                    narrow16,
    output logic                    out_valid,
    output logic [LANES*FP_W-1:0]   dst_vec
);
    // Control travelling beside the lane data, one set per stage
    logic              vld_a, vld_b, vld_c;
    logic [MODE_W-1:0] mode_a;
    logic              sat_a, sat_b;
    logic              nw_a, nw_b;
    logic [LANES-1:0]  msk_a, msk_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_a  <= 1'b0;
            vld_b  <= 1'b0;
            vld_c  <= 1'b0;
            mode_a <= '0;
            sat_a  <= 1'b0;
            sat_b  <= 1'b0;
            nw_a   <= 1'b0;
            nw_b   <= 1'b0;
            msk_a  <= '0;
            msk_b  <= '0;
        end else begin
            vld_a  <= in_valid;
            mode_a <= rnd_mode;
            sat_a  <= sat_en;
            nw_a   <= narrow16;
            msk_a  <= lane_mask;
            vld_b  <= vld_a;
            sat_b  <= sat_a;
            nw_b   <= nw_a;
            msk_b  <= msk_a;
            vld_c  <= vld_b;
        end
    end

    assign out_valid = vld_c;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        f2i_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .fp       (src_vec[g*FP_W +: FP_W]),
            .mode_a   (mode_a),
            .sat_b    (sat_b),
            .narrow_b (nw_b),
            .mbit_b   (msk_b[g]),
            .q        (dst_vec[g*FP_W +: FP_W])
        );
    end

endmodule

// File: rtl/f2i_vec_conv_chk.sv
module f2i_vec_conv_chk #(
    parameter int LANES = 64
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [LANES*32-1:0]   src_vec,
    input logic [LANES-1:0]      lane_mask,
    input logic                  sat_en,
    input logic                  narrow16,
    input logic                  out_valid,
    input logic [LANES*32-1:0]   dst_vec
);
    logic                v_d1, v_d2, v_d3;
    logic                s_d1, s_d2, s_d3;
    logic                n_d1, n_d2, n_d3;
    logic [LANES-1:0]    m_d1, m_d2, m_d3;
    logic [LANES*32-1:0] x_d1, x_d2, x_d3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {v_d1, v_d2, v_d3} <= '0;
            {s_d1, s_d2, s_d3} <= '0;
            {n_d1, n_d2, n_d3} <= '0;
            m_d1 <= '0; m_d2 <= '0; m_d3 <= '0;
            x_d1 <= '0; x_d2 <= '0; x_d3 <= '0;
        end else begin
            v_d1 <= in_valid;  v_d2 <= v_d1; v_d3 <= v_d2;
            s_d1 <= sat_en;    s_d2 <= s_d1; s_d3 <= s_d2;
            n_d1 <= narrow16;  n_d2 <= n_d1; n_d3 <= n_d2;
            m_d1 <= lane_mask; m_d2 <= m_d1; m_d3 <= m_d2;
            x_d1 <= src_vec;   x_d2 <= x_d1; x_d3 <= x_d2;
        end
    end

    assert_valid_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == v_d3);

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        assert_masked_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !m_d3[g]) |-> (dst_vec[g*32 +: 32] == 32'd0));

        assert_narrow_sext_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && n_d3) |-> (dst_vec[g*32+16 +: 16] == {16{dst_vec[g*32+15]}}));

        assert_nan_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && x_d3[g*32+23 +: 8] == 8'hFF && x_d3[g*32 +: 23] != 23'd0)
            |-> (dst_vec[g*32 +: 32] == 32'd0));

        assert_inf_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && s_d3 && m_d3[g] && x_d3[g*32 +: 32] == 32'h7F80_0000)
            |-> (dst_vec[g*32 +: 32] == (n_d3 ? 32'h0000_7FFF : 32'h7FFF_FFFF)));
    end

endmodule

bind f2i_vec_conv f2i_vec_conv_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .src_vec   (src_vec),
    .lane_mask (lane_mask),
    .sat_en    (sat_en),
    .narrow16  (narrow16),
    .out_valid (out_valid),
    .dst_vec   (dst_vec)
);

// File: tb/tb_f2i_vec_conv.sv
module tb_f2i_vec_conv;
    localparam int LANES = 64;
    localparam int VW    = LANES * 32;

    localparam logic [31:0] PAT [32] = '{
        32'h40200000, 32'h40600000, 32'hC0200000, 32'h3F000000,
        32'h3FC00000, 32'hBFC00000, 32'h3DCCCCCD, 32'hBE99999A,
        32'h40800000, 32'h40880000, 32'hC0880000, 32'h4F32D05E,
        32'hCF32D05E, 32'h4F000000, 32'hCF000000, 32'h53800000,
        32'h471C4000, 32'h46FFFF00, 32'hC7000080, 32'h7FC00000,
        32'h7F800000, 32'hFF800000, 32'h00000001, 32'h80000001,
        32'h80000000, 32'h00000000, 32'h3EFFFFFF, 32'hBF000000,
        32'h4EFFFFFF, 32'h7F7FFFFF, 32'h4B000001, 32'h4AFFFFFF
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [VW-1:0]    src_vec = '0;
    logic [LANES-1:0] lane_mask = '0;
    logic [2:0]       rnd_mode = '0;
    logic             sat_en = 1'b0;
    logic             narrow16 = 1'b0;
    logic             out_valid;
    logic [VW-1:0]    dst_vec;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic          v;
        logic [VW-1:0] d;
        string         tag;
    } exp_t;
    exp_t expq[$];

    always #4 clk = ~clk;

    f2i_vec_conv #(.LANES(LANES)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
        .lane_mask(lane_mask), .rnd_mode(rnd_mode), .sat_en(sat_en),
        .narrow16(narrow16), .out_valid(out_valid), .dst_vec(dst_vec)
    );

    // Behavioural lane model built on real arithmetic
    function automatic logic [31:0] ref_lane(input logic [31:0] b, input logic [2:0] md,
                                             input logic st, input logic nw, input logic mk);
        logic [7:0]  ex;
        logic [23:0] sig;
        logic        neg;
        real         a, f;
        longint      t, m, r, hi, lo;
        int          sh, eeff;
        ex  = b[30:23];
        neg = b[31];
        sig = {ex != 8'd0, b[22:0]};
        hi  = nw ? 64'sd32767 : 64'sd2147483647;
        lo  = nw ? -64'sd32768 : -64'sd2147483648;
        if (!mk) return 32'd0;
        if (ex == 8'hFF) begin
            if (b[22:0] != 23'd0 || !st) return 32'd0;
            return neg ? 32'(lo) : 32'(hi);
        end
        if (ex >= 8'd159) begin
            if (st) return neg ? 32'(lo) : 32'(hi);
            sh = int'(ex) - 150;
            m  = (sh < 64) ? (longint'(sig) << sh) : 64'sd0;
            r  = neg ? -m : m;
            return nw ? {{16{r[15]}}, r[15:0]} : r[31:0];
        end
        eeff = (ex == 8'd0) ? 1 : int'(ex);
        a = real'(sig) * (2.0 ** (eeff - 150));
        t = longint'(a);
        if (real'(t) > a) t = t - 1;
        f = a - real'(t);
        case (md)
            3'd1: m = (f > 0.0) ? t + 1 : t;
            3'd2: m = (neg && f > 0.0) ? t + 1 : t;
            3'd3: m = (!neg && f > 0.0) ? t + 1 : t;
            3'd4: m = t;
            3'd5: m = (f > 0.0) ? (t | 64'sd1) : t;
            default: m = (f > 0.5 || (f == 0.5 && t[0])) ? t + 1 : t;
        endcase
        r = neg ? -m : m;
        if (st) begin
            if (r > hi) r = hi;
            if (r < lo) r = lo;
        end
        return nw ? {{16{r[15]}}, r[15:0]} : r[31:0];
    endfunction

    function automatic logic [31:0] rand_f32();
        int          k;
        logic [7:0]  ex;
        k = $urandom_range(0, 9);
        if (k == 0)      ex = 8'h00;
        else if (k == 1) ex = 8'hFF;
        else             ex = 8'(100 + $urandom_range(0, 65));
        return {1'($urandom), ex, 23'($urandom)};
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // One clock: judge the result due now, then drive the next operand set
    task automatic cyc(input logic v, input logic [VW-1:0] s, input logic [LANES-1:0] mk,
                       input logic [2:0] md, input logic st, input logic nw, input string tag);
        exp_t e, n;
        @(negedge clk);
        e = expq.pop_front();
        checks++;
        if (out_valid !== e.v) begin
            fails++;
            $display("FAIL %s out_valid: got %b expected %b", e.tag, out_valid, e.v);
        end
        if (e.v) begin
            checks++;
            if (dst_vec !== e.d) begin
                fails++;
                for (int i = 0; i < LANES; i++) begin
                    if (dst_vec[i*32 +: 32] !== e.d[i*32 +: 32]) begin
                        $display("FAIL %s lane %0d: got %h expected %h", e.tag, i,
                                 dst_vec[i*32 +: 32], e.d[i*32 +: 32]);
                        break;
                    end
                end
            end
        end
        in_valid  = v;
        src_vec   = s;
        lane_mask = mk;
        rnd_mode  = md;
        sat_en    = st;
        narrow16  = nw;
        n.v   = v;
        n.tag = tag;
        for (int i = 0; i < LANES; i++)
            n.d[i*32 +: 32] = ref_lane(s[i*32 +: 32], md, st, nw, mk[i]);
        expq.push_back(n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [VW-1:0] pat_vec;
        exp_t idle;
        for (int i = 0; i < LANES; i++) pat_vec[i*32 +: 32] = PAT[i % 32];

        // R10: reset state
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || dst_vec !== '0) begin
            fails++;
            $display("FAIL R10 reset: got valid %b dst nonzero=%b expected 0 0",
                     out_valid, |dst_vec);
        end
        rst_n = 1'b1;
        idle.v = 1'b0; idle.d = '0; idle.tag = "R10 after reset";
        repeat (3) expq.push_back(idle);

        // R1 R2 R3 R4 R6 R7 R9: every mode, saturation and width, back to back
        for (int md = 0; md < 8; md++)
            for (int st = 0; st < 2; st++)
                for (int nw = 0; nw < 2; nw++)
                    cyc(1'b1, pat_vec, '1, 3'(md), 1'(st), 1'(nw),
                        $sformatf("R1 R2 R3 R4 R6 R7 R9 mode=%0d sat=%0d n16=%0d", md, st, nw));

        // R5: random masks over the special-value pattern
        for (int k = 0; k < 24; k++)
            cyc(1'b1, pat_vec, {$urandom, $urandom}, 3'($urandom_range(0, 7)),
                1'($urandom), 1'($urandom), "R5 mask merge");

        // R8: random stream with gaps in the valid strobe
        for (int k = 0; k < 300; k++) begin
            logic [VW-1:0] rv;
            for (int i = 0; i < LANES; i++) rv[i*32 +: 32] = rand_f32();
            cyc(1'($urandom_range(0, 3) != 0), rv, {$urandom, $urandom},
                3'($urandom_range(0, 7)), 1'($urandom), 1'($urandom), "R8 stream");
        end

        repeat (3) cyc(1'b0, '0, '0, 3'd0, 1'b0, 1'b0, "R8 drain");
        finish_run();
    end

endmodule